// File: doc/BRIEF.md
# Debug Address Match Comparator Bank

This block holds a set of instruction-address comparators and a separate set of data-address comparators for hardware debug. Software programs each slot through a small register port. A slot has a value register, which holds an aligned address, and a control register, which holds an enable bit, a privilege selection, access-type bits and a byte-lane select field. Every fetched instruction address and every load or store address is presented with a valid strobe. One cycle later the bank reports which slots matched, and it gives the index of the lowest-numbered matching slot.

An instruction comparator compares its value against the fetch address on a 4-byte granule. A data comparator compares on an 8-byte granule. The address bits below the granule then pick one bit of the byte-lane select field, and that bit must be set for the hit to count. A data hit also needs the slot's load or store bit to agree with the access kind. Every hit needs the slot's privilege selection to equal the level of the access. An identification register reports how many slots of each kind are built.

Top module: `dbg_match_bank`

## Requirements
- R1: Reset clears every value and control register, so they read back 0, and all hit outputs are 0 after reset.
- R2: An instruction slot can hit only when its value register equals the instruction address with bits [1:0] cleared.
- R3: A data slot can hit only when its value register equals the data address with bits [2:0] cleared.
- R4: After the value compare, a hit also requires a set bit in the byte-lane field. For instruction slots this is control bit 8+addr[1:0] (field [11:8]). For data slots it is control bit 8+addr[2:0] (field [15:8]).
- R5: Control bit 0 enables the slot. A slot with bit 0 clear never hits, so writing 0 to a control register disables the slot.
- R6: A data hit requires control bit 3 for a load (`da_store`=0) or control bit 4 for a store (`da_store`=1). Setting both bits watches both kinds of access.
- R7: Control bit 1 selects the privilege level the slot watches: 0 for level 0, 1 for level 1. A slot hits only when this bit equals the access's level input.
- R8: Setting `reg_addr[6]` reads the identification register. Bits [3:0] hold the instruction slot count minus one and bits [7:4] hold the data slot count minus one. With `reg_addr[6]`=0, bits [5:4] select the register group (0 instruction value, 1 instruction control, 2 data value, 3 data control) and bits [3:0] select the slot. Writes to slots that are not built are ignored, and reads of them return 0.
- R9: The hit vector flags every slot that hits in the same cycle. The index output gives the lowest-numbered hitting slot, and is 0 when nothing hits.
- R10: The hit flag, vector and index are registered. They reflect the access presented with its valid strobe at the previous clock edge, and they are 0 after any edge where that strobe was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register select: ID flag, group, slot |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| ia_valid | input | 1 | Instruction address valid |
| ia_addr | input | AW | Instruction address |
| ia_el | input | 1 | Privilege level of the fetch |
| da_valid | input | 1 | Data address valid |
| da_addr | input | AW | Data address |
| da_store | input | 1 | 0 = load, 1 = store |
| da_el | input | 1 | Privilege level of the data access |
| bp_hit | output | 1 | Any instruction slot hit |
| bp_vec | output | NUM_BP | Instruction slot hit vector |
| bp_idx | output | 4 | Lowest hitting instruction slot |
| wp_hit | output | 1 | Any data slot hit |
| wp_vec | output | NUM_WP | Data slot hit vector |
| wp_idx | output | 4 | Lowest hitting data slot |

## Verification
The bench targets addresses one granule away from a slot's value and offsets inside the granule whose byte-lane bit is clear. A design with the wrong alignment mask or the wrong lane bit would report false hits or miss true ones. It also checks load-only slots against stores, slots programmed for the other privilege level, and slots disabled by writing zero; a design that skipped any of these filters would raise spurious hits. Several slots are made to hit at once, so that a priority encoder scanning in the wrong direction would report the wrong index. Writes to slots that are not built must be seen to have no effect on readback.

// File: rtl/dbg_match_bank.sv
module dbg_match_bank #(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4,
  parameter int AW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  input  logic              ia_valid,
  input  logic [AW-1:0]     ia_addr,
  input  logic              ia_el,
  input  logic              da_valid,
  input  logic [AW-1:0]     da_addr,
  input  logic              da_store,
  input  logic              da_el,
  output logic              bp_hit,
  output logic [NUM_BP-1:0] bp_vec,
  output logic [3:0]        bp_idx,
  output logic              wp_hit,
  output logic [NUM_WP-1:0] wp_vec,
  output logic [3:0]        wp_idx
);
  localparam logic [3:0] BP_ID = 4'(NUM_BP - 1);
  localparam logic [3:0] WP_ID = 4'(NUM_WP - 1);

  logic [AW-1:0] bpv [NUM_BP];
  logic [AW-1:0] bpc [NUM_BP];
  logic [AW-1:0] wpv [NUM_WP];
  logic [AW-1:0] wpc [NUM_WP];

  logic [1:0] grp;
  logic [3:0] slot;
  assign grp  = reg_addr[5:4];
  assign slot = reg_addr[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BP; i++) begin
        bpv[i] <= '0;
        bpc[i] <= '0;
      end
      for (int i = 0; i < NUM_WP; i++) begin
        wpv[i] <= '0;
        wpc[i] <= '0;
      end
    end else if (reg_we && !reg_addr[6]) begin
      for (int i = 0; i < NUM_BP; i++)
        if (slot == 4'(i)) begin
          if (grp == 2'd0) bpv[i] <= reg_wdata;
          if (grp == 2'd1) bpc[i] <= reg_wdata;
        end
      for (int i = 0; i < NUM_WP; i++)
        if (slot == 4'(i)) begin
          if (grp == 2'd2) wpv[i] <= reg_wdata;
          if (grp == 2'd3) wpc[i] <= reg_wdata;
        end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[6]) begin
      reg_rdata[3:0] = BP_ID;
      reg_rdata[7:4] = WP_ID;
    end else begin
      for (int i = 0; i < NUM_BP; i++)
        if (slot == 4'(i)) begin
          if (grp == 2'd0) reg_rdata = bpv[i];
          if (grp == 2'd1) reg_rdata = bpc[i];
        end
      for (int i = 0; i < NUM_WP; i++)
        if (slot == 4'(i)) begin
          if (grp == 2'd2) reg_rdata = wpv[i];
          if (grp == 2'd3) reg_rdata = wpc[i];
        end
    end
  end

  logic [AW-1:0]     ia_gran, da_gran;
  logic [NUM_BP-1:0] bp_raw;
  logic [NUM_WP-1:0] wp_raw;
  assign ia_gran = {ia_addr[AW-1:2], 2'b00};
  assign da_gran = {da_addr[AW-1:3], 3'b000};

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic [3:0] lanes;
    assign lanes     = bpc[i][11:8];
    assign bp_raw[i] = bpc[i][0] && (bpc[i][1] == ia_el) &&
                       (bpv[i] == ia_gran) && lanes[ia_addr[1:0]];
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    logic [7:0] lanes;
    assign lanes     = wpc[i][15:8];
    assign wp_raw[i] = wpc[i][0] && (wpc[i][1] == da_el) &&
                       (wpv[i] == da_gran) && lanes[da_addr[2:0]] &&
                       (da_store ? wpc[i][4] : wpc[i][3]);
  end

  function automatic logic [3:0] first_bp(input logic [NUM_BP-1:0] v);
    first_bp = '0;
    for (int i = NUM_BP - 1; i >= 0; i--)
      if (v[i]) first_bp = 4'(i);
  endfunction

  function automatic logic [3:0] first_wp(input logic [NUM_WP-1:0] v);
    first_wp = '0;
    for (int i = NUM_WP - 1; i >= 0; i--)
      if (v[i]) first_wp = 4'(i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_hit <= 1'b0;
      bp_vec <= '0;
      bp_idx <= '0;
      wp_hit <= 1'b0;
      wp_vec <= '0;
      wp_idx <= '0;
    end else begin
      bp_hit <= ia_valid && (|bp_raw);
      bp_vec <= ia_valid ? bp_raw : '0;
      bp_idx <= ia_valid ? first_bp(bp_raw) : '0;
      wp_hit <= da_valid && (|wp_raw);
      wp_vec <= da_valid ? wp_raw : '0;
      wp_idx <= da_valid ? first_wp(wp_raw) : '0;
    end
  end
endmodule

// File: rtl/dbg_match_bank_chk.sv
module dbg_match_bank_chk #(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4,
  parameter int AW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        reg_addr,
  input logic [AW-1:0]     reg_rdata,
  input logic              ia_valid,
  input logic              da_valid,
  input logic              bp_hit,
  input logic [NUM_BP-1:0] bp_vec,
  input logic [3:0]        bp_idx,
  input logic              wp_hit,
  input logic [NUM_WP-1:0] wp_vec,
  input logic [3:0]        wp_idx
);
  AST_BP_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ia_valid) |-> (bp_vec == '0 && !bp_hit && bp_idx == '0)); // R10
  AST_WP_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(da_valid) |-> (wp_vec == '0 && !wp_hit && wp_idx == '0)); // R10
  AST_BP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> ((|(bp_vec & (NUM_BP'(1) << bp_idx))) &&
                ((bp_vec & ((NUM_BP'(1) << bp_idx) - NUM_BP'(1))) == '0))); // R9
  AST_WP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> ((|(wp_vec & (NUM_WP'(1) << wp_idx))) &&
                ((wp_vec & ((NUM_WP'(1) << wp_idx) - NUM_WP'(1))) == '0))); // R9
  AST_AFTER_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (!bp_hit && !wp_hit)); // R1
  AST_ID_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[6] |-> (reg_rdata[3:0] == 4'(NUM_BP - 1) &&
                     reg_rdata[7:4] == 4'(NUM_WP - 1))); // R8
endmodule

bind dbg_match_bank dbg_match_bank_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ia_valid(ia_valid), .da_valid(da_valid),
  .bp_hit(bp_hit), .bp_vec(bp_vec), .bp_idx(bp_idx),
  .wp_hit(wp_hit), .wp_vec(wp_vec), .wp_idx(wp_idx)
);

// File: tb/dbg_match_bank_tb.sv
module dbg_match_bank_tb;
  localparam int NBP = 6;
  localparam int NWP = 4;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ia_valid = 0, ia_el = 0, da_valid = 0, da_store = 0, da_el = 0;
  logic [31:0] ia_addr = '0, da_addr = '0;
  logic bp_hit, wp_hit;
  logic [NBP-1:0] bp_vec;
  logic [NWP-1:0] wp_vec;
  logic [3:0] bp_idx, wp_idx;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_bpv [NBP], m_bpc [NBP], m_wpv [NWP], m_wpc [NWP];

  always #10 clk = ~clk;

  dbg_match_bank #(.NUM_BP(NBP), .NUM_WP(NWP), .AW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ia_valid(ia_valid), .ia_addr(ia_addr), .ia_el(ia_el),
    .da_valid(da_valid), .da_addr(da_addr), .da_store(da_store), .da_el(da_el),
    .bp_hit(bp_hit), .bp_vec(bp_vec), .bp_idx(bp_idx),
    .wp_hit(wp_hit), .wp_vec(wp_vec), .wp_idx(wp_idx));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NBP-1:0] exp_bp(logic [31:0] a, logic el);
    logic [NBP-1:0] v = '0;
    for (int i = 0; i < NBP; i++)
      v[i] = m_bpc[i][0] && m_bpc[i][1] == el && m_bpv[i] == (a & ~32'h3) &&
             m_bpc[i][8 + int'(a[1:0])];
    return v;
  endfunction

  function automatic logic [NWP-1:0] exp_wp(logic [31:0] a, logic st, logic el);
    logic [NWP-1:0] v = '0;
    for (int i = 0; i < NWP; i++)
      v[i] = m_wpc[i][0] && m_wpc[i][1] == el && m_wpv[i] == (a & ~32'h7) &&
             m_wpc[i][8 + int'(a[2:0])] && (st ? m_wpc[i][4] : m_wpc[i][3]);
    return v;
  endfunction

  function automatic logic [3:0] lowest(logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic wr(logic [1:0] g, logic [3:0] s, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = {1'b0, g, s}; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (g == 0 && s < NBP) m_bpv[s] = d;
    if (g == 1 && s < NBP) m_bpc[s] = d;
    if (g == 2 && s < NWP) m_wpv[s] = d;
    if (g == 3 && s < NWP) m_wpc[s] = d;
  endtask

  task automatic rd_chk(string req, logic [6:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic probe(string req, logic [31:0] ia, logic iel, logic [31:0] da, logic st, logic del);
    logic [NBP-1:0] eb;
    logic [NWP-1:0] ew;
    eb = exp_bp(ia, iel);
    ew = exp_wp(da, st, del);
    @(negedge clk);
    ia_valid = 1; ia_addr = ia; ia_el = iel;
    da_valid = 1; da_addr = da; da_store = st; da_el = del;
    @(negedge clk);
    chk({req, " bp_vec"}, 32'(bp_vec), 32'(eb));
    chk({req, " bp_hit"}, 32'(bp_hit), 32'(|eb));
    chk({req, " bp_idx"}, 32'(bp_idx), 32'(lowest(16'(eb))));
    chk({req, " wp_vec"}, 32'(wp_vec), 32'(ew));
    chk({req, " wp_hit"}, 32'(wp_hit), 32'(|ew));
    chk({req, " wp_idx"}, 32'(wp_idx), 32'(lowest(16'(ew))));
    ia_valid = 0; da_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    void'($urandom(32'd4242));
    for (int i = 0; i < NBP; i++) begin m_bpv[i] = 0; m_bpc[i] = 0; end
    for (int i = 0; i < NWP; i++) begin m_wpv[i] = 0; m_wpc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    chk("R1 bp_hit", 32'(bp_hit), 0);
    chk("R1 wp_hit", 32'(wp_hit), 0);
    rd_chk("R1 bpc0", 7'h10, 0);
    rd_chk("R1 wpv3", 7'h23, 0);
    // R8: ID and unimplemented slots
    rd_chk("R8 id", 7'h40, 32'h35);
    wr(2'd0, 4'd9, 32'hDEAD_BEE0);
    rd_chk("R8 unbuilt bp slot", 7'h09, 0);
    wr(2'd3, 4'd5, 32'hFFFF);
    rd_chk("R8 unbuilt wp slot", 7'h35, 0);
    // R2/R4: instruction compare, lane select
    wr(2'd0, 4'd2, 32'h0000_1000);
    wr(2'd1, 4'd2, 32'h0000_0501);
    rd_chk("R8 readback bpc2", 7'h12, 32'h501);
    probe("R2 exact", 32'h1000, 0, 32'h0, 0, 0);
    probe("R4 lane2 set", 32'h1002, 0, 32'h0, 0, 0);
    probe("R4 lane1 clear", 32'h1001, 0, 32'h0, 0, 0);
    probe("R2 next granule", 32'h1004, 0, 32'h0, 0, 0);
    // R7: privilege
    probe("R7 wrong level", 32'h1000, 1, 32'h0, 0, 0);
    // R9: multi-hit lowest
    wr(2'd0, 4'd4, 32'h0000_1000);
    wr(2'd1, 4'd4, 32'h0000_0F01);
    wr(2'd0, 4'd5, 32'h0000_1000);
    wr(2'd1, 4'd5, 32'h0000_0F01);
    probe("R9 multi", 32'h1000, 0, 32'h0, 0, 0);
    // R5: zero disables
    wr(2'd1, 4'd2, 32'h0);
    probe("R5 disabled slot", 32'h1000, 0, 32'h0, 0, 0);
    wr(2'd1, 4'd4, 32'h0000_0F00);
    probe("R5 enable clear", 32'h1000, 0, 32'h0, 0, 0);
    // R3/R6: data compare and type
    wr(2'd2, 4'd1, 32'h0000_2008);
    wr(2'd3, 4'd1, 32'h0000_FF0B);
    probe("R6 load hit", 32'h0, 0, 32'h200F, 0, 1);
    probe("R6 store filtered", 32'h0, 0, 32'h200F, 1, 1);
    probe("R3 next granule", 32'h0, 0, 32'h2010, 0, 1);
    wr(2'd3, 4'd1, 32'h0000_101B);
    probe("R6 store lane4", 32'h0, 0, 32'h200C, 1, 1);
    probe("R4 wp lane3 clear", 32'h0, 0, 32'h200B, 1, 1);
    // R10: idle cycle
    @(negedge clk);
    chk("R10 idle bp", 32'(bp_vec), 0);
    chk("R10 idle wp", 32'(wp_vec), 0);
    // random
    base = 32'h4000_1000;
    for (int it = 0; it < 400; it++) begin
      if (it % 10 == 0) begin
        for (int s = 0; s < NBP; s++) begin
          wr(2'd0, 4'(s), base + 32'(4 * $urandom_range(0, 5)));
          wr(2'd1, 4'(s), {20'h0, 4'($urandom), 5'h0, 1'b0, 1'($urandom), 1'($urandom_range(0, 3) != 0)});
        end
        for (int s = 0; s < NWP; s++) begin
          wr(2'd2, 4'(s), base + 32'(8 * $urandom_range(0, 3)));
          wr(2'd3, 4'(s), {16'h0, 8'($urandom), 3'h0, 2'($urandom), 1'b0, 1'($urandom), 1'($urandom_range(0, 3) != 0)});
        end
      end
      probe("R9 random", base + 32'($urandom_range(0, 27)), 1'($urandom),
            base + 32'($urandom_range(0, 35)), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule